// File: doc/BRIEF.md
# ECC Error Event Capture Registers

This block keeps a snapshot of the most recent reported error-correction event on an on-chip RAM, so software can inspect it after the fact. The ECC checker next to the RAM raises one of two single-cycle pulses: one for a corrected single-bit error, and one for an uncorrectable error. Each pulse comes with its own payload: the access address, the access attributes, the 64-bit data word and the 8-bit syndrome. Two report-enable bits from an external configuration register decide which event types are recorded.

When an enabled event arrives, the block loads its payload into read-only capture registers and sets a sticky status flag for that event type. Software reads the capture registers and the status word over a simple one-cycle request/response register port. It clears a flag by writing 1 to that flag's bit. If the build parameter marks RAM error reporting as absent, every access on the port ends with an error response.

Top module: `ecc_evt_capture`

## Requirements
- R1: After reset, both status flags read 0, and every capture register reads 0.
- R2: An enabled event loads its address, attributes, data and syndrome on the same clock edge. Register map (byte offsets): address at 0x60, syndrome at 0x64 in bits 7:0, attributes at 0x68 in bits 7:0, data bits 31:0 at 0x6C, data bits 63:32 at 0x70. Unused upper bits read 0.
- R3: The status word is at offset 0x40. A corrected single-bit event sets bit 0, and an uncorrectable event sets bit 1. Bits 31:2 read 0.
- R4: An event whose report enable is clear changes neither the capture registers nor the flags.
- R5: When both event types are enabled and occur in the same cycle, the uncorrectable event's payload is captured and both flags are set.
- R6: A new enabled event overwrites the captured contents even while an earlier flag is still set.
- R7: Writing 1 to a status bit clears that flag, and writing 0 leaves it unchanged. A set and a clear of the same flag in the same cycle leaves the flag set.
- R8: A write to any capture register completes without an error response and changes nothing.
- R9: An access to an offset outside the map above, or to an offset not aligned to 4 bytes, returns an error response with read data 0.
- R10: With reporting configured as absent, every access returns an error response with read data 0.
- R11: Every request gets exactly one response, on the cycle after the request. Read data is 0 on writes and on error responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sbc_en_i | input | 1 | Report enable for corrected single-bit events |
| nce_en_i | input | 1 | Report enable for uncorrectable events |
| sbc_evt_i | input | 1 | Corrected single-bit event pulse |
| sbc_addr_i | input | 32 | Address of the corrected access |
| sbc_attr_i | input | 8 | Attributes of the corrected access |
| sbc_data_i | input | 64 | Data of the corrected access |
| sbc_synd_i | input | 8 | Syndrome of the corrected access |
| nce_evt_i | input | 1 | Uncorrectable event pulse |
| nce_addr_i | input | 32 | Address of the uncorrectable access |
| nce_attr_i | input | 8 | Attributes of the uncorrectable access |
| nce_data_i | input | 64 | Data of the uncorrectable access |
| nce_synd_i | input | 8 | Syndrome of the uncorrectable access |
| req_i | input | 1 | Register access request, one cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Response valid |
| rdata_o | output | 32 | Read data |
| err_o | output | 1 | Error response |

## Verification
The assertions assume that both event pulses are sampled on the clock edge together with their payloads, and that a register request lasts a single cycle, with no back-pressure on the response. The bench drives every input at the falling edge. Each payload is held for exactly one cycle and then replaced by fresh random values. The bench issues requests and events freely in the same cycle, including events that coincide with a flag clear. A second instance, built with reporting absent, sees the same stimulus, so its error behaviour is checked on every access.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam logic [7:0] OFF_STATUS = 8'h40;
  localparam logic [7:0] OFF_ADDR   = 8'h60;
  localparam logic [7:0] OFF_SYND   = 8'h64;
  localparam logic [7:0] OFF_ATTR   = 8'h68;
  localparam logic [7:0] OFF_DATA0  = 8'h6C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ADDR,
    SEL_SYND,
    SEL_ATTR,
    SEL_DATA
  } reg_sel_e;
endpackage

// File: rtl/ecc_cap_flags.sv
module ecc_cap_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sbc_evt_i,
  input  logic       nce_evt_i,
  input  logic       sbc_en_i,
  input  logic       nce_en_i,
  input  logic [1:0] clr_i,
  output logic       cap_en_o,
  output logic       pick_nce_o,
  output logic       sbc_flag_o,
  output logic       nce_flag_o
);
  logic set_sbc, set_nce;
  logic sbc_q, nce_q;

  assign set_sbc    = sbc_evt_i & sbc_en_i;
  assign set_nce    = nce_evt_i & nce_en_i;
  assign cap_en_o   = set_sbc | set_nce;
  assign pick_nce_o = set_nce;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sbc_q <= 1'b0;
      nce_q <= 1'b0;
    end else begin
      sbc_q <= set_sbc | (sbc_q & ~clr_i[0]);
      nce_q <= set_nce | (nce_q & ~clr_i[1]);
    end
  end

  assign sbc_flag_o = sbc_q;
  assign nce_flag_o = nce_q;

  AST_SBC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbc_evt_i && sbc_en_i) |=> sbc_flag_o); // R3
  AST_NCE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nce_evt_i && nce_en_i) |=> nce_flag_o); // R3
  AST_SBC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(sbc_evt_i && sbc_en_i) && !clr_i[0]) |=> $stable(sbc_flag_o)); // R4
  AST_NCE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(nce_evt_i && nce_en_i) && !clr_i[1]) |=> $stable(nce_flag_o)); // R4
  AST_SBC_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[0] && !(sbc_evt_i && sbc_en_i)) |=> !sbc_flag_o); // R7
  AST_NCE_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[1] && !(nce_evt_i && nce_en_i)) |=> !nce_flag_o); // R7
endmodule

// File: rtl/ecc_cap_store.sv
module ecc_cap_store #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ATTR_W = 8,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SYND_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_en_i,
  input  logic              pick_nce_i,
  input  logic [ADDR_W-1:0] sbc_addr_i,
  input  logic [ATTR_W-1:0] sbc_attr_i,
  input  logic [DATA_W-1:0] sbc_data_i,
  input  logic [SYND_W-1:0] sbc_synd_i,
  input  logic [ADDR_W-1:0] nce_addr_i,
  input  logic [ATTR_W-1:0] nce_attr_i,
  input  logic [DATA_W-1:0] nce_data_i,
  input  logic [SYND_W-1:0] nce_synd_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ATTR_W-1:0] attr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [SYND_W-1:0] synd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      attr_o <= '0;
      data_o <= '0;
      synd_o <= '0;
    end else if (cap_en_i) begin
      addr_o <= pick_nce_i ? nce_addr_i : sbc_addr_i;
      attr_o <= pick_nce_i ? nce_attr_i : sbc_attr_i;
      data_o <= pick_nce_i ? nce_data_i : sbc_data_i;
      synd_o <= pick_nce_i ? nce_synd_i : sbc_synd_i;
    end
  end

  AST_NCE_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en_i && pick_nce_i) |=> (addr_o == $past(nce_addr_i)) && (data_o == $past(nce_data_i))
                                && (synd_o == $past(nce_synd_i)) && (attr_o == $past(nce_attr_i))); // R5
  AST_SBC_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en_i && !pick_nce_i) |=> (addr_o == $past(sbc_addr_i)) && (data_o == $past(sbc_data_i))
                                 && (synd_o == $past(sbc_synd_i)) && (attr_o == $past(sbc_attr_i))); // R2
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |=> $stable(addr_o) && $stable(data_o) && $stable(synd_o) && $stable(attr_o)); // R4
endmodule

// File: rtl/ecc_cap_port.sv
module ecc_cap_port
  import ecc_cap_pkg::*;
#(
  parameter int unsigned BUS_AW  = 8,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ATTR_W  = 8,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned SYND_W  = 8,
  parameter bit          PRESENT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              sbc_flag_i,
  input  logic              nce_flag_i,
  input  logic [ADDR_W-1:0] addr_cap_i,
  input  logic [ATTR_W-1:0] attr_cap_i,
  input  logic [DATA_W-1:0] data_cap_i,
  input  logic [SYND_W-1:0] synd_cap_i,
  output logic [1:0]        clr_o,
  output logic              rvalid_o,
  output logic [31:0]       rdata_o,
  output logic              err_o
);
  localparam int unsigned NUM_DW = DATA_W / 32;
  localparam int unsigned IDX_W  = (NUM_DW > 1) ? $clog2(NUM_DW) : 1;
  localparam logic [BUS_AW-1:0] DATA_END = BUS_AW'(OFF_DATA0 + 4 * NUM_DW);

  reg_sel_e          sel;
  logic [IDX_W-1:0]  widx;
  logic              err_c;
  logic [31:0]       rd_c;
  logic [31:0]       dwords [NUM_DW];
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[31:2];

  for (genvar g = 0; g < NUM_DW; g++) begin : g_dword
    assign dwords[g] = data_cap_i[g*32 +: 32];
  end

  always_comb begin
    sel  = SEL_NONE;
    widx = '0;
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i == BUS_AW'(OFF_STATUS))      sel = SEL_STATUS;
      else if (addr_i == BUS_AW'(OFF_ADDR))   sel = SEL_ADDR;
      else if (addr_i == BUS_AW'(OFF_SYND))   sel = SEL_SYND;
      else if (addr_i == BUS_AW'(OFF_ATTR))   sel = SEL_ATTR;
      else if (addr_i >= BUS_AW'(OFF_DATA0) && addr_i < DATA_END) begin
        sel  = SEL_DATA;
        widx = IDX_W'((addr_i - BUS_AW'(OFF_DATA0)) >> 2);
      end
    end
  end

  assign err_c = !PRESENT || (sel == SEL_NONE);

  always_comb begin
    case (sel)
      SEL_STATUS: rd_c = {30'b0, nce_flag_i, sbc_flag_i};
      SEL_ADDR:   rd_c = 32'(addr_cap_i);
      SEL_SYND:   rd_c = 32'(synd_cap_i);
      SEL_ATTR:   rd_c = 32'(attr_cap_i);
      SEL_DATA:   rd_c = dwords[widx];
      default:    rd_c = '0;
    endcase
  end

  assign clr_o = (req_i && we_i && !err_c && sel == SEL_STATUS) ? wdata_i[1:0] : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= req_i;
      err_o    <= req_i && err_c;
      rdata_o  <= (req_i && !we_i && !err_c) ? rd_c : '0;
    end
  end

  AST_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rvalid_o); // R11
  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rvalid_o && !err_o); // R11
  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == '0); // R9

  if (!PRESENT) begin : g_absent
    AST_ABSENT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rvalid_o |-> err_o); // R10
  end else begin : g_present
    AST_CAP_WR_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == BUS_AW'(OFF_ADDR)) |=> rvalid_o && !err_o); // R8
  end
endmodule

// File: rtl/ecc_evt_capture.sv
module ecc_evt_capture #(
  parameter int unsigned BUS_AW  = 8,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ATTR_W  = 8,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned SYND_W  = 8,
  parameter bit          PRESENT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sbc_en_i,
  input  logic              nce_en_i,
  input  logic              sbc_evt_i,
  input  logic [ADDR_W-1:0] sbc_addr_i,
  input  logic [ATTR_W-1:0] sbc_attr_i,
  input  logic [DATA_W-1:0] sbc_data_i,
  input  logic [SYND_W-1:0] sbc_synd_i,
  input  logic              nce_evt_i,
  input  logic [ADDR_W-1:0] nce_addr_i,
  input  logic [ATTR_W-1:0] nce_attr_i,
  input  logic [DATA_W-1:0] nce_data_i,
  input  logic [SYND_W-1:0] nce_synd_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              rvalid_o,
  output logic [31:0]       rdata_o,
  output logic              err_o
);
  logic              cap_en, pick_nce, sbc_flag, nce_flag;
  logic [1:0]        clr;
  logic [ADDR_W-1:0] addr_q;
  logic [ATTR_W-1:0] attr_q;
  logic [DATA_W-1:0] data_q;
  logic [SYND_W-1:0] synd_q;

  ecc_cap_flags i_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sbc_evt_i  (sbc_evt_i),
    .nce_evt_i  (nce_evt_i),
    .sbc_en_i   (sbc_en_i),
    .nce_en_i   (nce_en_i),
    .clr_i      (clr),
    .cap_en_o   (cap_en),
    .pick_nce_o (pick_nce),
    .sbc_flag_o (sbc_flag),
    .nce_flag_o (nce_flag)
  );

  ecc_cap_store #(
    .ADDR_W (ADDR_W), .ATTR_W (ATTR_W), .DATA_W (DATA_W), .SYND_W (SYND_W)
  ) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_en_i   (cap_en),
    .pick_nce_i (pick_nce),
    .sbc_addr_i (sbc_addr_i),
    .sbc_attr_i (sbc_attr_i),
    .sbc_data_i (sbc_data_i),
    .sbc_synd_i (sbc_synd_i),
    .nce_addr_i (nce_addr_i),
    .nce_attr_i (nce_attr_i),
    .nce_data_i (nce_data_i),
    .nce_synd_i (nce_synd_i),
    .addr_o     (addr_q),
    .attr_o     (attr_q),
    .data_o     (data_q),
    .synd_o     (synd_q)
  );

  ecc_cap_port #(
    .BUS_AW (BUS_AW), .ADDR_W (ADDR_W), .ATTR_W (ATTR_W),
    .DATA_W (DATA_W), .SYND_W (SYND_W), .PRESENT (PRESENT)
  ) i_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .sbc_flag_i (sbc_flag),
    .nce_flag_i (nce_flag),
    .addr_cap_i (addr_q),
    .attr_cap_i (attr_q),
    .data_cap_i (data_q),
    .synd_cap_i (synd_q),
    .clr_o      (clr),
    .rvalid_o   (rvalid_o),
    .rdata_o    (rdata_o),
    .err_o      (err_o)
  );
endmodule

// File: tb/test_ecc_evt_capture.sv
`timescale 1ns/1ps
module test_ecc_evt_capture;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        sbc_en = 0, nce_en = 0, sbc_evt = 0, nce_evt = 0;
  logic [31:0] sbc_addr = 0, nce_addr = 0;
  logic [7:0]  sbc_attr = 0, nce_attr = 0, sbc_synd = 0, nce_synd = 0;
  logic [63:0] sbc_data = 0, nce_data = 0;
  logic        req = 0, we = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic        rvalid, err, a_rvalid, a_err;
  logic [31:0] rdata, a_rdata;

  int checks = 0;
  int errors = 0;

  // model state
  logic [31:0] m_addr = 0;
  logic [7:0]  m_attr = 0, m_synd = 0;
  logic [63:0] m_data = 0;
  logic        m_sbc = 0, m_nce = 0;

  ecc_evt_capture i_ecc_evt_capture (
    .clk_i(clk), .rst_ni(rst_n), .sbc_en_i(sbc_en), .nce_en_i(nce_en),
    .sbc_evt_i(sbc_evt), .sbc_addr_i(sbc_addr), .sbc_attr_i(sbc_attr),
    .sbc_data_i(sbc_data), .sbc_synd_i(sbc_synd),
    .nce_evt_i(nce_evt), .nce_addr_i(nce_addr), .nce_attr_i(nce_attr),
    .nce_data_i(nce_data), .nce_synd_i(nce_synd),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rvalid_o(rvalid), .rdata_o(rdata), .err_o(err)
  );

  ecc_evt_capture #(.PRESENT(1'b0)) i_absent (
    .clk_i(clk), .rst_ni(rst_n), .sbc_en_i(sbc_en), .nce_en_i(nce_en),
    .sbc_evt_i(sbc_evt), .sbc_addr_i(sbc_addr), .sbc_attr_i(sbc_attr),
    .sbc_data_i(sbc_data), .sbc_synd_i(sbc_synd),
    .nce_evt_i(nce_evt), .nce_addr_i(nce_addr), .nce_attr_i(nce_attr),
    .nce_data_i(nce_data), .nce_synd_i(nce_synd),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rvalid_o(a_rvalid), .rdata_o(a_rdata), .err_o(a_err)
  );

  function automatic bit map_ok(input logic [7:0] a);
    return a == 8'h40 || a == 8'h60 || a == 8'h64 || a == 8'h68 || a == 8'h6C || a == 8'h70;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h40:   return {30'b0, m_nce, m_sbc};
      8'h60:   return m_addr;
      8'h64:   return {24'b0, m_synd};
      8'h68:   return {24'b0, m_attr};
      8'h6C:   return m_data[31:0];
      8'h70:   return m_data[63:32];
      default: return 32'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check response at next negedge, then update the model
  task automatic cyc(input string tag, input bit s, input bit n, input bit se, input bit ne,
                     input bit rq, input bit w, input logic [7:0] a, input logic [31:0] wd);
    logic        e_err;
    logic [31:0] e_rd;
    bit          set_s, set_n;
    sbc_addr = $urandom; sbc_attr = 8'($urandom); sbc_synd = 8'($urandom);
    sbc_data = {$urandom, $urandom};
    nce_addr = $urandom; nce_attr = 8'($urandom); nce_synd = 8'($urandom);
    nce_data = {$urandom, $urandom};
    sbc_evt = s; nce_evt = n; sbc_en = se; nce_en = ne;
    req = rq; we = w; addr = a; wdata = wd;
    e_err = rq && !map_ok(a);
    e_rd  = (rq && !w && !e_err) ? exp_rd(a) : 32'b0;
    @(posedge clk);
    @(negedge clk);
    chk({tag, "/R11 valid"}, 64'(rvalid), 64'(rq));
    if (rq) begin
      chk({tag, " err"}, 64'(err), 64'(e_err));
      chk({tag, " rdata"}, 64'(rdata), 64'(e_rd));
      chk("R10 absent err", 64'(a_err), 64'd1);
      chk("R10 absent rdata", 64'(a_rdata), 64'd0);
    end
    set_s = s && se;
    set_n = n && ne;
    if (rq && w && a == 8'h40) begin
      if (wd[0]) m_sbc = 1'b0;
      if (wd[1]) m_nce = 1'b0;
    end
    if (set_s) m_sbc = 1'b1;
    if (set_n) m_nce = 1'b1;
    if (set_n) begin
      m_addr = nce_addr; m_attr = nce_attr; m_data = nce_data; m_synd = nce_synd;
    end else if (set_s) begin
      m_addr = sbc_addr; m_attr = sbc_attr; m_data = sbc_data; m_synd = sbc_synd;
    end
    sbc_evt = 0; nce_evt = 0; req = 0; we = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    cyc(tag, 0, 0, 1, 1, 1, 0, a, 32'h0);
  endtask

  task automatic rd_all(input string tag);
    rd(tag, 8'h40); rd(tag, 8'h60); rd(tag, 8'h64);
    rd(tag, 8'h68); rd(tag, 8'h6C); rd(tag, 8'h70);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pool [8];
    void'($urandom(32'd1234));
    pool = '{8'h40, 8'h60, 8'h64, 8'h68, 8'h6C, 8'h70, 8'h44, 8'h61};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: all zero after reset (model starts at zero)
    rd("R1", 8'h40); rd("R1", 8'h60); rd("R1", 8'h64);
    rd("R1", 8'h68); rd("R1", 8'h6C); rd("R1", 8'h70);

    // R2 R3: corrected event captured, bit 0 set
    cyc("R2", 1, 0, 1, 1, 0, 0, 8'h0, 32'h0);
    rd_all("R2");
    // R6: uncorrectable overwrites while bit 0 still set; R3 bit 1
    cyc("R6", 0, 1, 1, 1, 0, 0, 8'h0, 32'h0);
    rd_all("R6");
    // R4: disabled types change nothing
    cyc("R4", 1, 0, 0, 1, 0, 0, 8'h0, 32'h0);
    cyc("R4", 0, 1, 1, 0, 0, 0, 8'h0, 32'h0);
    cyc("R4", 1, 1, 0, 0, 0, 0, 8'h0, 32'h0);
    rd_all("R4");
    // R7: write 0 no effect, write 1 clears, set beats clear
    cyc("R7", 0, 0, 1, 1, 1, 1, 8'h40, 32'h0);
    rd("R7", 8'h40);
    cyc("R7", 0, 0, 1, 1, 1, 1, 8'h40, 32'h1);
    rd("R7", 8'h40);
    cyc("R7", 0, 1, 1, 1, 1, 1, 8'h40, 32'h2);
    rd("R7", 8'h40);
    cyc("R7", 0, 0, 1, 1, 1, 1, 8'h40, 32'hFFFF_FFFF);
    rd("R7", 8'h40);
    // R5: both at once
    cyc("R5", 1, 1, 1, 1, 0, 0, 8'h0, 32'h0);
    rd_all("R5");
    // R8: writes to capture registers ignored, no error
    cyc("R8", 0, 0, 1, 1, 1, 1, 8'h60, 32'hDEAD_BEEF);
    cyc("R8", 0, 0, 1, 1, 1, 1, 8'h6C, 32'h1234_5678);
    cyc("R8", 0, 0, 1, 1, 1, 1, 8'h64, 32'hFF);
    rd_all("R8");
    // R9: unmapped and misaligned
    rd("R9", 8'h44); rd("R9", 8'h61); rd("R9", 8'h74); rd("R9", 8'h00);
    cyc("R9", 0, 0, 1, 1, 1, 1, 8'h42, 32'h3);
    rd("R9", 8'h40);

    for (int i = 0; i < 600; i++) begin
      cyc("R2 rand", ($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 3) != 0,
          ($urandom % 3) != 0, ($urandom % 2) == 0, ($urandom % 4) == 0,
          pool[$urandom % 8], $urandom);
    end
    rd_all("R6 final");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule